// File: doc/BRIEF.md
# Bidirectional Thermal Throttle Controller

This block manages a shared, active-low "chip hot" line that runs between the chip and its system board. The line is open-drain, so either side may pull it low. The block takes a digital over-temperature flag from an on-die sensor comparator and a thermal-control enable bit. When the chip is too hot and control is enabled, the block pulls the line low. It also watches the line so that it can tell when the system is pulling it low from outside.

The block gives the clocking logic a throttle-active output. Throttling starts on the chip's own over-temperature or on an external assertion. Throttling that the system starts lasts exactly as long as the system holds the line low, plus the synchronizer latency.

A two-bit sticky status register records what caused throttling. Software clears each bit by writing a one to it. The pad is modelled as a drive-enable output (the pad pulls low while it is high) and a raw sampled input.

Top module: `thermal_hot_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `hot_drive_en`, `throttle` and `status` all read 0 after that edge.
- R2: `hot_drive_en` is high in the cycle after any edge at which `tc_en` and `overtemp` are both high, and low after any other edge.
- R3: An external assertion (the system holds `hot_line_n` low while the block is not driving it) raises `throttle` exactly SYNC_STAGES+1 clock edges after the line first goes low, provided `tc_en` is high.
- R4: `throttle` is registered, and after each edge it equals `tc_en` AND (`overtemp` OR the synchronized external assertion), all taken at that edge.
- R5: Throttling caused only by the system stays high for as long as the line is held low. It falls exactly SYNC_STAGES+1 edges after the system releases the line.
- R6: When the line is low only because of the block's own drive, the block never sees an external assertion. `throttle` then falls at the same edge as `hot_drive_en`, and `status[1]` is not set.
- R7: With `tc_en` low at an edge, nothing changes in the cycle after it: `hot_drive_en` and `throttle` are 0, and no status bit becomes set.
- R8: `status[0]` (internal cause) sets on any edge where `tc_en` and `overtemp` are high. `status[1]` (external cause) sets on any edge where `tc_en` is high and a synchronized external assertion is present. Both bits hold until cleared.
- R9: A 1 in bit i of `status_clr` at an edge clears `status[i]`. If a set condition for the same bit occurs at that same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tc_en | input | 1 | Thermal-control enable |
| overtemp | input | 1 | Sensor comparator flag, synchronous to clk |
| hot_line_n | input | 1 | Raw sampled level of the shared hot line, active low |
| hot_drive_en | output | 1 | Pull the shared line low while high |
| throttle | output | 1 | Throttle request to the clocking logic |
| status | output | 2 | Sticky cause: bit 0 internal, bit 1 external |
| status_clr | input | 2 | Write-one-to-clear strobes for `status` |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This checks that the delay line for the masking drive stays aligned with a longer synchronizer. It also moves the R3 and R5 latency edges to different cycles than the default would give.

The bench closes the loop on the line itself by driving the block's input from the wired-AND of its own drive and the system's pull. This exercises own-drive masking, overlap of the two causes and release timing under the same feedback path that the real pad gives.

// File: rtl/thermal_pkg.sv
// Shared types for the thermal throttle controller.
// Assumes: status is a two-bit cause vector; the bit positions below are
// visible to software and must not move.
package thermal_pkg;
    localparam int CAUSE_INT = 0;
    localparam int CAUSE_EXT = 1;
    localparam int CAUSE_W   = 2;

    typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/hot_sync.sv
// Multi-stage shift synchronizer / delay line.
// Purpose: bring an asynchronous level into the clk domain, or delay a
// synchronous level by the same number of stages so the two line up.
// Assumes: STAGES >= 2; reset value is the inactive level 0.
module hot_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hot_status.sv
// Sticky throttle-cause register with write-one-to-clear.
// Purpose: latch each cause until software clears it.
// Assumes: a set and a clear of the same bit at the same edge resolve to set.
module hot_status
    import thermal_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  cause_t set_i,
    input  cause_t clr_i,
    output cause_t stat_o
);
    cause_t stat_q;

    // Clear the acknowledged bits, then OR in the new causes so that set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | set_i;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/thermal_hot_ctrl.sv
// Bidirectional thermal throttle controller (top).
// Purpose: drive the shared active-low hot line on internal over-temperature,
// detect external assertions of the same line, request throttling and record
// the cause.
// Assumes: overtemp is synchronous to clk; hot_line_n is asynchronous and is
// low whenever this block or the system pulls it; the pad's pull-low follows
// hot_drive_en within one cycle.
module thermal_hot_ctrl
    import thermal_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tc_en,
    input  logic               overtemp,
    input  logic               hot_line_n,
    output logic               hot_drive_en,
    output logic               throttle,
    output logic [CAUSE_W-1:0] status,
    input  logic [CAUSE_W-1:0] status_clr
);
    logic   drive_q;
    logic   throttle_q;
    logic   line_low_s;
    logic   drive_dly;
    logic   ext_seen;
    logic   int_hot;
    cause_t cause_set;

    assign int_hot = tc_en & overtemp;

    // Register the pad drive so that the line follows a clean flop.
    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= int_hot;
    end

    // Synchronize the sampled line (asserted = low).
    hot_sync #(.STAGES(SYNC_STAGES)) u_line_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (~hot_line_n),
        .q     (line_low_s)
    );

    // Delay the own drive by the same depth so that it masks the line exactly.
    hot_sync #(.STAGES(SYNC_STAGES)) u_drive_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (drive_q),
        .q     (drive_dly)
    );

    assign ext_seen = line_low_s & ~drive_dly;

    // Register the throttle request from either cause, gated by the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) throttle_q <= 1'b0;
        else        throttle_q <= tc_en & (overtemp | ext_seen);
    end

    // Compose the cause set vector.
    always_comb begin
        cause_set            = '0;
        cause_set[CAUSE_INT] = int_hot;
        cause_set[CAUSE_EXT] = tc_en & ext_seen;
    end

    hot_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cause_set),
        .clr_i  (status_clr),
        .stat_o (status)
    );

    assign hot_drive_en = drive_q;
    assign throttle     = throttle_q;

    AST_DRIVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_en && overtemp) |=> hot_drive_en); // R2
    AST_DRIVE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_en |=> !hot_drive_en); // R7
    AST_THROTTLE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !tc_en |=> !throttle); // R7
    AST_HOT_THROTTLES: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_en && overtemp) |=> throttle); // R4
    AST_INT_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_en && overtemp) |=> status[CAUSE_INT]); // R8
    AST_INT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[CAUSE_INT] && !status_clr[CAUSE_INT]) |=> status[CAUSE_INT]); // R8
    AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[CAUSE_EXT] && !status_clr[CAUSE_EXT]) |=> status[CAUSE_EXT]); // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_clr[CAUSE_INT] && !(tc_en && overtemp)) |=> !status[CAUSE_INT]); // R9
endmodule

// File: tb/thermal_hot_ctrl_test.sv
module thermal_hot_ctrl_test;
    localparam int STG = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tc_en = 1'b0;
    logic       overtemp = 1'b0;
    logic       sys_pull = 1'b0;
    logic [1:0] status_clr = 2'b00;
    logic       hot_drive_en;
    logic       throttle;
    logic [1:0] status;
    logic       hot_line_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Wired-AND of both pull-downs on the shared line.
    assign hot_line_n = ~(hot_drive_en | sys_pull);

    thermal_hot_ctrl #(.SYNC_STAGES(STG)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tc_en        (tc_en),
        .overtemp     (overtemp),
        .hot_line_n   (hot_line_n),
        .hot_drive_en (hot_drive_en),
        .throttle     (throttle),
        .status       (status),
        .status_clr   (status_clr)
    );

    always #10 clk = ~clk;

    // Behavioural reference model.
    bit       m_drive, m_throt;
    bit [1:0] m_stat;
    bit       q_line[$];
    bit       q_drv[$];

    always @(posedge clk) begin
        bit ext, line_low;
        bit [1:0] setv;
        if (!rst_n) begin
            m_drive = 0; m_throt = 0; m_stat = 0;
            q_line.delete(); q_drv.delete();
            for (int i = 0; i < STG; i++) begin q_line.push_back(0); q_drv.push_back(0); end
        end else begin
            line_low = m_drive | sys_pull;
            ext = q_line[STG-1] & ~q_drv[STG-1];
            m_throt = tc_en & (overtemp | ext);
            setv = {tc_en & ext, tc_en & overtemp};
            m_stat = (m_stat & ~status_clr) | setv;
            q_line.push_front(line_low); void'(q_line.pop_back());
            q_drv.push_front(m_drive);   void'(q_drv.pop_back());
            m_drive = tc_en & overtemp;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock, then compare every output against the model.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk("R2 drive", hot_drive_en, m_drive);
        chk("R4 throttle", throttle, m_throt);
        chk("R8 status", status, m_stat);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        overtemp = 1; tc_en = 1; sys_pull = 1;
        steps(3);
        chk("R1 reset drive", hot_drive_en, 0);
        chk("R1 reset throttle", throttle, 0);
        chk("R1 reset status", status, 0);
        overtemp = 0; sys_pull = 0; rst_n = 1;
        steps(5);

        // Internal over-temperature only (R2, R6).
        overtemp = 1;
        step();
        chk("R2 drive up", hot_drive_en, 1);
        chk("R4 throttle up", throttle, 1);
        steps(6);
        chk("R6 no ext cause", status[1], 0);
        overtemp = 0;
        step();
        chk("R6 throttle falls with drive", throttle, 0);
        chk("R2 drive down", hot_drive_en, 0);
        steps(STG + 2);
        chk("R6 still no ext", status, 2'b01);
        status_clr = 2'b01; step(); status_clr = 0;
        chk("R9 clear int", status, 2'b00);

        // External assertion only (R3, R5).
        sys_pull = 1;
        steps(STG);
        chk("R3 not yet", throttle, 0);
        step();
        chk("R3 throttle up", throttle, 1);
        chk("R8 ext cause", status, 2'b10);
        steps(10);
        chk("R5 held", throttle, 1);
        sys_pull = 0;
        steps(STG);
        chk("R5 still held", throttle, 1);
        step();
        chk("R5 released", throttle, 0);
        chk("R8 sticky ext", status, 2'b10);

        // Set wins over clear (R9).
        overtemp = 1; status_clr = 2'b11;
        step();
        status_clr = 0; overtemp = 0;
        chk("R9 set wins", status, 2'b01);
        steps(STG + 2);

        // Disabled: nothing happens (R7).
        status_clr = 2'b11; step(); status_clr = 0;
        tc_en = 0; overtemp = 1; sys_pull = 1;
        steps(8);
        chk("R7 no drive", hot_drive_en, 0);
        chk("R7 no throttle", throttle, 0);
        chk("R7 no status", status, 0);
        overtemp = 0; sys_pull = 0; tc_en = 1;
        steps(STG + 2);

        // Mixed stimulus compared cycle by cycle.
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 7) == 0) overtemp = ~overtemp;
            if ($urandom_range(0, 9) == 0) sys_pull = ~sys_pull;
            if ($urandom_range(0, 40) == 0) tc_en = ~tc_en;
            status_clr = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule